// File: doc/BRIEF.md
# Divided Timer Base with Three Pulse Generators

This block turns a 19.2 MHz reference tick enable into a slower common timer tick. It then builds three independent pulse trains on that common tick. A divider counts reference ticks and emits one common tick every (value + 1) of them, so a value of 191 gives a 100 kHz base, one tick per 10 µs. Each of the three generators counts common ticks. It emits a one-cycle pulse at the end of a period chosen by a 3-bit granularity code, then starts again. Downstream timers use these pulses as their time base.

Software sets the block up through one write port that has two words. The divider word carries the division value and an enable bit. The granularity word carries the three codes. The division value can only be changed while the divider is stopped. The usual sequence is therefore: stop the divider, write the new value, then start it again. The new value and the enable bit may also be written in one word, if the divider is stopped when that word arrives. While the divider is stopped, no pulses appear and every generator keeps its partial count. Writing a different code to a generator restarts its count, so no period of the wrong length is ever emitted.

Top module: `tick_pulse_gen`

## Requirements
- R1: After reset the divider is stopped and no pulse occurs. The granularity codes reset to 3 for generator 0 and to 4 for generators 1 and 2.
- R2: When enabled, the divider gives one common tick for every (value + 1) cycles in which `ref_tick` is high. Cycles with `ref_tick` low do not advance it.
- R3: A write with `cfg_sel`=0 is a divider word: bits [8:0] hold the value and bit 31 is the enable. If the divider is stopped when the word arrives, the value is taken and bit 31 sets the enable.
- R4: While the divider is running, the value field of a divider word is ignored. Only bit 31 acts, and a 0 there stops the divider.
- R5: While the divider is stopped, no common ticks and no pulses occur, and each generator keeps its count. After a restart, each generator carries on from its kept count.
- R6: A write with `cfg_sel`=1 is a granularity word. Generator i takes its code from bits [3i+2:3i]. The codes give these periods in common ticks: 0→1, 1→2, 2→5, 3→10, 4→100.
- R7: A generator's pulse goes high for one cycle, in the cycle after the edge that carries the final common tick of its period. When the period is one tick and a tick comes every cycle, the pulse stays high.
- R8: Writing a code that differs from a generator's current code clears that generator's count and drops any tick in the same cycle. Writing the code it already has changes nothing.
- R9: The long codes give these periods in common ticks: 5→1000, 6→10000, 7→65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference tick enable at 19.2 MHz |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Word select: 0 divider, 1 granularity |
| cfg_wdata | input | 32 | Configuration write data |
| pulse | output | 3 | One-cycle pulse per generator |

## Verification
The assertions assume that a new division value reaches the block only while the divider is stopped, or in the same word that starts it. They also assume that a granularity write is a single-cycle strobe. The stimulus follows the stop, write, start order every time the value changes. It writes a new value while the divider is running only to show that the value is ignored. The bench drives `ref_tick` either high on every cycle or high on every other cycle, so the time of each tick can be worked out from the requirements alone.

// File: rtl/tpg_pkg.sv
`timescale 1ns/1ps
package tpg_pkg;

    localparam int TICK_W = 16;
    localparam int GCODE_W = 3;

    // Period of a granularity code, counted in 10 us common ticks
    function automatic logic [TICK_W-1:0] gran_ticks(input logic [GCODE_W-1:0] code);
        logic [TICK_W-1:0] t;
        case (code)
            3'd0:    t = 16'd1;
            3'd1:    t = 16'd2;
            3'd2:    t = 16'd5;
            3'd3:    t = 16'd10;
            3'd4:    t = 16'd100;
            3'd5:    t = 16'd1000;
            3'd6:    t = 16'd10000;
            default: t = 16'd65535;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/tpg_divider.sv
`timescale 1ns/1ps
module tpg_divider #(
    parameter int DIV_W   = 9,
    parameter int RST_DIV = 191
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             wr,
    input  logic [DIV_W-1:0] wr_val,
    input  logic             wr_en,
    output logic             tick,
    output logic             en,
    output logic [DIV_W-1:0] val,
    output logic [DIV_W-1:0] cnt
);

    localparam logic [DIV_W-1:0] RST_VAL = DIV_W'(RST_DIV);

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] val;
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t s_q, s_d;

    assign tick = s_q.en & ref_tick & (s_q.cnt == s_q.val);

    always_comb begin
        s_d = s_q;
        // Counter parks at zero while stopped so a restart begins a full ratio
        if (!s_q.en) begin
            s_d.cnt = '0;
        end else if (tick) begin
            s_d.cnt = '0;
        end else if (ref_tick) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        if (wr) begin
            if (!s_q.en) begin
                s_d.val = wr_val;
            end
            s_d.en = wr_en;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{en: 1'b0, val: RST_VAL, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign en  = s_q.en;
    assign val = s_q.val;
    assign cnt = s_q.cnt;

endmodule

// File: rtl/tpg_pulse_gen.sv
`timescale 1ns/1ps
module tpg_pulse_gen #(
    parameter int CODE_W   = tpg_pkg::GCODE_W,
    parameter int CNT_W    = tpg_pkg::TICK_W,
    parameter int RST_CODE = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              code_wr,
    input  logic [CODE_W-1:0] code_in,
    output logic              pulse,
    output logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  cnt
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  cnt;
        logic              pulse;
    } gen_state_t;

    gen_state_t s_q, s_d;
    logic [CNT_W-1:0] last_d;

    assign last_d = CNT_W'(tpg_pkg::gran_ticks(s_q.code)) - 1'b1;

    always_comb begin
        s_d       = s_q;
        s_d.pulse = 1'b0;
        if (code_wr && (code_in != s_q.code)) begin
            s_d.code = code_in;
            s_d.cnt  = '0;
        end else if (tick) begin
            if (s_q.cnt == last_d) begin
                s_d.cnt   = '0;
                s_d.pulse = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{code: CODE_W'(RST_CODE), cnt: '0, pulse: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign pulse = s_q.pulse;
    assign code  = s_q.code;
    assign cnt   = s_q.cnt;

endmodule

// File: rtl/tick_pulse_gen.sv
`timescale 1ns/1ps
module tick_pulse_gen #(
    parameter int NUM_GEN = 3,
    parameter int DIV_W   = 9,
    parameter int CFG_W   = 32,
    parameter int CODE_W  = tpg_pkg::GCODE_W,
    parameter int CNT_W   = tpg_pkg::TICK_W,
    parameter int RST_DIV = 191,
    parameter logic [NUM_GEN*CODE_W-1:0] RST_CODES = {3'd4, 3'd4, 3'd3}
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    output logic [NUM_GEN-1:0] pulse
);

    logic                      com_tick;
    logic                      div_en;
    logic [DIV_W-1:0]          div_val;
    logic [DIV_W-1:0]          div_cnt;
    logic                      div_wr;
    logic                      gran_wr;
    logic [NUM_GEN*CODE_W-1:0] gen_code;
    logic [NUM_GEN*CNT_W-1:0]  gen_cnt;
    logic                      unused_cfg;

    assign div_wr     = cfg_we & ~cfg_sel;
    assign gran_wr    = cfg_we & cfg_sel;
    assign unused_cfg = ^cfg_wdata;

    tpg_divider #(
        .DIV_W   (DIV_W),
        .RST_DIV (RST_DIV)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .wr       (div_wr),
        .wr_val   (cfg_wdata[DIV_W-1:0]),
        .wr_en    (cfg_wdata[CFG_W-1]),
        .tick     (com_tick),
        .en       (div_en),
        .val      (div_val),
        .cnt      (div_cnt)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        tpg_pulse_gen #(
            .CODE_W   (CODE_W),
            .CNT_W    (CNT_W),
            .RST_CODE (int'(RST_CODES[g*CODE_W +: CODE_W]))
        ) u_gen (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (com_tick),
            .code_wr (gran_wr),
            .code_in (cfg_wdata[g*CODE_W +: CODE_W]),
            .pulse   (pulse[g]),
            .code    (gen_code[g*CODE_W +: CODE_W]),
            .cnt     (gen_cnt[g*CNT_W +: CNT_W])
        );
    end

endmodule

// File: rtl/tpg_checker.sv
`timescale 1ns/1ps
module tpg_checker #(
    parameter int NUM_GEN = 3,
    parameter int DIV_W   = 9,
    parameter int CODE_W  = 3,
    parameter int CNT_W   = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      com_tick,
    input logic                      div_en,
    input logic [DIV_W-1:0]          div_val,
    input logic [DIV_W-1:0]          div_cnt,
    input logic [NUM_GEN-1:0]        pulse,
    input logic [NUM_GEN*CODE_W-1:0] gen_code,
    input logic [NUM_GEN*CNT_W-1:0]  gen_cnt
);

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        div_en |-> (div_cnt <= div_val));

    p_val_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_en && $past(div_en)) |-> (div_val == $past(div_val)));

    p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !div_en |=> (pulse == '0));

    p_pulse_after_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulse) |-> $past(com_tick));

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chk
        p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (gen_code[g*CODE_W +: CODE_W] != $past(gen_code[g*CODE_W +: CODE_W]))
            |-> (gen_cnt[g*CNT_W +: CNT_W] == '0));

        p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
            gen_cnt[g*CNT_W +: CNT_W]
            < CNT_W'(tpg_pkg::gran_ticks(gen_code[g*CODE_W +: CODE_W])));
    end

endmodule

bind tick_pulse_gen tpg_checker #(
    .NUM_GEN (NUM_GEN),
    .DIV_W   (DIV_W),
    .CODE_W  (CODE_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .com_tick (com_tick),
    .div_en   (div_en),
    .div_val  (div_val),
    .div_cnt  (div_cnt),
    .pulse    (pulse),
    .gen_code (gen_code),
    .gen_cnt  (gen_cnt)
);

// File: tb/sim_tick_pulse_gen.sv
`timescale 1ns/1ps
module sim_tick_pulse_gen;

    localparam int NG = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_tick = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_sel = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [NG-1:0] pulse;

    int    cyc = 0;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    bit m_en = 1'b0;
    int m_val = 191;
    int m_dcnt = 0;
    int m_code [NG] = '{3, 4, 4};
    int m_cnt [NG] = '{0, 0, 0};
    int expq [NG][$];

    tick_pulse_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .pulse     (pulse)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int code_period(int c);
        case (c)
            0: return 1;
            1: return 2;
            2: return 5;
            3: return 10;
            4: return 100;
            5: return 1000;
            6: return 10000;
            default: return 65535;
        endcase
    endfunction

    // Predict the effect of the coming clock edge n from the requirements
    task automatic model_edge(int n, bit we, bit sel, logic [31:0] d, bit rf);
        bit tk;
        tk = m_en && rf && (m_dcnt == m_val);
        for (int i = 0; i < NG; i++) begin
            int nc;
            nc = int'(d[3*i +: 3]);
            if (we && sel && nc != m_code[i]) begin
                m_code[i] = nc;
                m_cnt[i] = 0;
            end else if (tk) begin
                if (m_cnt[i] == code_period(m_code[i]) - 1) begin
                    expq[i].push_back(n);
                    m_cnt[i] = 0;
                end else begin
                    m_cnt[i]++;
                end
            end
        end
        if (!m_en) m_dcnt = 0;
        else if (tk) m_dcnt = 0;
        else if (rf) m_dcnt++;
        if (we && !sel) begin
            if (!m_en) m_val = int'(d[8:0]);
            m_en = d[31];
        end
    endtask

    task automatic drive(bit we, bit sel, logic [31:0] d, bit rf);
        cfg_we    = we;
        cfg_sel   = sel;
        cfg_wdata = d;
        ref_tick  = rf;
        model_edge(cyc + 1, we, sel, d, rf);
        @(negedge clk);
    endtask

    task automatic write_cfg(bit sel, logic [31:0] d);
        drive(1'b1, sel, d, 1'b1);
    endtask

    task automatic run(int n, bit alt);
        for (int k = 0; k < n; k++) begin
            drive(1'b0, 1'b0, 32'h0, alt ? ((cyc % 2) == 0) : 1'b1);
        end
    endtask

    // Monitor: pop expected pulse times and compare with observed pulses
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int i = 0; i < NG; i++) begin
                while (expq[i].size() > 0 && expq[i][0] < cyc) begin
                    n_vec++;
                    n_bad++;
                    $display("FAIL %s gen%0d: actual no pulse at cycle %0d, expected pulse",
                             cur_req, i, expq[i][0]);
                    void'(expq[i].pop_front());
                end
                if (pulse[i]) begin
                    n_vec++;
                    if (expq[i].size() > 0 && expq[i][0] == cyc) begin
                        void'(expq[i].pop_front());
                    end else begin
                        n_bad++;
                        $display("FAIL %s gen%0d: actual pulse at cycle %0d, expected %0d",
                                 cur_req, i, cyc,
                                 (expq[i].size() > 0) ? expq[i][0] : -1);
                    end
                end
            end
        end
    end

    initial begin
        // R1: held in reset, then released with the divider stopped
        repeat (5) begin
            @(negedge clk);
            n_vec++;
            if (pulse !== '0) begin
                n_bad++;
                $display("FAIL R1 reset: actual pulse=%b, expected 000", pulse);
            end
        end
        rst_n = 1'b1;
        run(20, 1'b0);

        // R1/R3: start with value 0; reset codes give 10/100/100 tick periods
        cur_req = "R1";
        write_cfg(1'b0, 32'h8000_0000);
        run(250, 1'b0);

        // R6/R7: codes 0,1,2 -> 1,2,5 ticks
        cur_req = "R6";
        write_cfg(1'b1, 32'h0000_0088);
        run(30, 1'b0);

        // R5: stop, hold counts, then R3 restart with value 3 (ratio 4)
        cur_req = "R5";
        write_cfg(1'b0, 32'h0000_0000);
        run(20, 1'b0);
        cur_req = "R3";
        write_cfg(1'b0, 32'h8000_0003);
        run(60, 1'b0);

        // R4: value written while running is ignored
        cur_req = "R4";
        write_cfg(1'b0, 32'h8000_0009);
        run(60, 1'b0);

        // R2: reference tick on every other cycle only
        cur_req = "R2";
        run(80, 1'b1);

        // R8: same codes have no effect, changed code restarts gen2
        cur_req = "R8";
        write_cfg(1'b1, 32'h0000_0088);
        run(7, 1'b0);
        write_cfg(1'b1, 32'h0000_00C8);
        run(60, 1'b0);

        // R9: long codes 5, 6, 7 at a 10 us-per-cycle ratio of 1
        cur_req = "R9";
        write_cfg(1'b0, 32'h0000_0000);
        write_cfg(1'b0, 32'h8000_0000);
        write_cfg(1'b1, 32'h0000_01F5);
        run(65600, 1'b0);

        done = 1'b1;
        for (int i = 0; i < NG; i++) begin
            n_vec++;
            if (expq[i].size() != 0) begin
                n_bad++;
                $display("FAIL end gen%0d: actual %0d pulses missing, expected 0",
                         i, expq[i].size());
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(150000 * 20);
        n_vec++;
        n_bad++;
        done = 1'b1;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule